// File: doc/BRIEF.md
# System Control Register Bank With Access Side-Effects

This block is a bank of sixteen memory-mapped system control registers on a simple single-cycle bus. The bus carries an address, write and read strobes, an access-size code and write data. The block answers with registered read data and a one-cycle error pulse. Most registers simply hold what is written to them. Several act on the access itself:
- a refresh counter advances each time it is read;
- a translation-control register turns its invalidate bit into a one-cycle pulse and never keeps that bit;
- a page-entry-high register emits a flush pulse when its low address-space-ID byte changes;
- the event-code and page-assist registers drop the high bits of written data.

Two bus-configuration registers are optional parts of the bank. An accompanying feature input tells whether they are present. Accessing them while that input is low still stores and returns data, but it flags an error. The real translation buffer, cache and refresh engine live elsewhere and only see the two pulses.

Top module: `ctrl_regbank`

## Requirements
- R1: After synchronous reset every register, the read data, the error flag and both pulses are zero.
- R2: The refresh counter (offset 0x10, 16-bit) returns its current value on a legal read and then holds that value plus one, wrapping from 0xFFFF to 0. A legal write loads it directly.
- R3: A legal write to the translation-control register (offset 0x20) with data bit 2 set gives a tlb_inval pulse exactly one cycle later. Bit 2 of the stored value is always zero, and all other bits are kept.
- R4: A legal write to the page-entry-high register (offset 0x24) gives an asid_flush pulse one cycle later only when written bits 7:0 differ from the stored bits 7:0. All 32 bits are stored.
- R5: The trap-code, exception-code and interrupt-code registers (offsets 0x30, 0x34, 0x38) keep data bits 10:0. Bits 31:11 read as zero.
- R6: The page-assist register (offset 0x2C) keeps data bits 3:0 only.
- R7: The optional bus-configuration registers (offset 0x08, 16-bit, and offset 0x0C, 32-bit) raise the error pulse on any access while feat_en is low. A legal-size access still stores or returns data.
- R8: The clock-control register (offset 0x14, 16-bit) reads as zero, and a write to it is an error with no effect. The wait-control register (0x18) and memory-control register (0x1C) are 32-bit, ignore writes, read as zero and raise no error.
- R9: Registers sit at byte offset 4*k for k = 0..15. Size code 0 is byte, 1 is 16-bit, 2 is 32-bit and 3 is reserved. The 16-bit registers (offsets 0x04, 0x08, 0x10, 0x14) need code 1, and all others need code 2. A misaligned address, an offset of 0x40 or above, or a wrong size raises the error pulse and changes nothing. Such a read returns zero.
- R10: Read data appears in the cycle after a legal read and is zero in every other cycle. The error flag is high only in the cycle after a faulty access.
- R11: When bus_wr and bus_rd are both high, only the write is performed. The read data stays zero and the refresh counter does not advance on that read.
- R12: The plain storage registers keep every bit of their width: offset 0x00 (32-bit), 0x04 (16-bit), 0x28 (32-bit) and 0x3C (32-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Optional bus-configuration registers present |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 reserved) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle error pulse |
| tlb_inval | output | 1 | One-cycle translation invalidate pulse |
| asid_flush | output | 1 | One-cycle flush pulse on an address-space-ID change |

## Verification
Assertions watch on every cycle that each pulse has a matching write in the cycle before it, and that read-back of the masked registers never shows dropped bits. They also check that the zero-reading registers return zero, that byte and optional-register accesses raise the error, and that read data stays quiet outside read responses. What they cannot see is stored history. The bench sweeps every offset, size, strobe combination and feature setting against an arithmetic model. That sweep alone shows:
- the counter sequence and its wrap;
- that a rewrite of an unchanged ID byte stays silent;
- that rejected accesses leave the contents untouched.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int NUM_REGS = 16;
    localparam int REG_W    = 32;
    localparam int HALF_W   = 16;
    localparam int ASID_W   = 8;
    localparam int CODE_W   = 11;
    localparam int AUX_W    = 4;
    localparam int INV_BIT  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        RG_BUSA    = 4'd0,
        RG_BUSB    = 4'd1,
        RG_BUSC    = 4'd2,
        RG_BUSD    = 4'd3,
        RG_REFCNT  = 4'd4,
        RG_CLKCTL  = 4'd5,
        RG_WAITCTL = 4'd6,
        RG_MEMCTL  = 4'd7,
        RG_MMUCTL  = 4'd8,
        RG_PTEHI   = 4'd9,
        RG_PTELO   = 4'd10,
        RG_PTEAUX  = 4'd11,
        RG_TRAP    = 4'd12,
        RG_EXC     = 4'd13,
        RG_INT     = 4'd14,
        RG_CACHE   = 4'd15
    } reg_id_e;

    typedef struct packed {
        logic    hit;
        reg_id_e id;
        logic    size_ok;
        logic    gated;
        logic    rd_only;
    } dec_t;

    function automatic logic is_half(reg_id_e id);
        return id inside {RG_BUSB, RG_BUSC, RG_REFCNT, RG_CLKCTL};
    endfunction

    function automatic logic [REG_W-1:0] keep_mask(reg_id_e id);
        logic [REG_W-1:0] m;
        case (id)
            RG_CLKCTL, RG_WAITCTL, RG_MEMCTL: m = '0;
            RG_BUSB, RG_BUSC, RG_REFCNT:      m = {{(REG_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            RG_TRAP, RG_EXC, RG_INT:          m = {{(REG_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};
            RG_PTEAUX:                        m = {{(REG_W-AUX_W){1'b0}}, {AUX_W{1'b1}}};
            RG_MMUCTL:                        m = ~(REG_W'(1) << INV_BIT);
            default:                          m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int BASE_LSB = 2;
    localparam int TOP      = BASE_LSB + IDX_W;

    logic [ADDR_W-1:0] upper;
    reg_id_e           id;

    always_comb begin
        upper       = addr >> TOP;
        id          = reg_id_e'(addr[TOP-1:BASE_LSB]);
        dec.hit     = (addr[BASE_LSB-1:0] == '0) && (upper == '0);
        dec.id      = id;
        dec.size_ok = is_half(id) ? (acc_size_e'(size) == SZ_HALF)
                                  : (acc_size_e'(size) == SZ_WORD);
        dec.gated   = (id == RG_BUSC) || (id == RG_BUSD);
        dec.rd_only = (id == RG_CLKCTL);
    end
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
    import regbank_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  reg_id_e                          id,
    input  logic [REG_W-1:0]                 wdata,
    output logic [NUM_REGS-1:0][REG_W-1:0]   store,
    output logic                             inval_p,
    output logic                             flush_p
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] q;
        localparam reg_id_e MY_ID = reg_id_e'(g);

        if (g == int'(RG_REFCNT)) begin : g_count
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && id == MY_ID) begin
                    q <= wdata & keep_mask(MY_ID);
                end else if (rd_en && id == MY_ID) begin
                    q <= {{(REG_W-HALF_W){1'b0}}, q[HALF_W-1:0] + HALF_W'(1)};
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && id == MY_ID) begin
                    q <= wdata & keep_mask(MY_ID);
                end
            end
        end

        assign store[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inval_p <= 1'b0;
            flush_p <= 1'b0;
        end else begin
            inval_p <= wr_en && (id == RG_MMUCTL) && wdata[INV_BIT];
            flush_p <= wr_en && (id == RG_PTEHI) &&
                       (wdata[ASID_W-1:0] != store[RG_PTEHI][ASID_W-1:0]);
        end
    end
endmodule

// File: rtl/ctrl_rdmux.sv
module ctrl_rdmux
    import regbank_pkg::*;
(
    input  logic [NUM_REGS-1:0][REG_W-1:0] store,
    input  reg_id_e                        id,
    output logic [REG_W-1:0]               rd_val
);
    always_comb begin
        if (id == RG_CLKCTL) rd_val = '0;
        else                 rd_val = store[id];
    end
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              feat_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              tlb_inval,
    output logic              asid_flush
);
    dec_t                           dec;
    logic [NUM_REGS-1:0][REG_W-1:0] store;
    logic [REG_W-1:0]               rd_val;
    logic                           legal, wr_acc, rd_acc, err_next;

    ctrl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .dec  (dec)
    );

    always_comb begin
        legal    = dec.hit && dec.size_ok && !(bus_wr && dec.rd_only);
        wr_acc   = bus_wr && legal;
        rd_acc   = bus_rd && !bus_wr && legal;
        err_next = (bus_wr || bus_rd) && (!legal || (dec.gated && !feat_en));
    end

    ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_acc),
        .rd_en   (rd_acc),
        .id      (dec.id),
        .wdata   (bus_wdata),
        .store   (store),
        .inval_p (tlb_inval),
        .flush_p (asid_flush)
    );

    ctrl_rdmux u_mux (
        .store  (store),
        .id     (dec.id),
        .rd_val (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_acc ? rd_val : '0;
            bus_err   <= err_next;
        end
    end
endmodule

// File: rtl/ctrl_regbank_chk.sv
module ctrl_regbank_chk
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              feat_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_size,
    input logic              wdata_inv,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              tlb_inval,
    input logic              asid_flush
);
    localparam logic [ADDR_W-1:0] A_BUSC = ADDR_W'(int'(RG_BUSC) * 4);
    localparam logic [ADDR_W-1:0] A_BUSD = ADDR_W'(int'(RG_BUSD) * 4);
    localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(int'(RG_CLKCTL) * 4);
    localparam logic [ADDR_W-1:0] A_WAIT = ADDR_W'(int'(RG_WAITCTL) * 4);
    localparam logic [ADDR_W-1:0] A_MEM  = ADDR_W'(int'(RG_MEMCTL) * 4);
    localparam logic [ADDR_W-1:0] A_MMU  = ADDR_W'(int'(RG_MMUCTL) * 4);
    localparam logic [ADDR_W-1:0] A_PTEH = ADDR_W'(int'(RG_PTEHI) * 4);
    localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(int'(RG_PTEAUX) * 4);
    localparam logic [ADDR_W-1:0] A_TRAP = ADDR_W'(int'(RG_TRAP) * 4);
    localparam logic [ADDR_W-1:0] A_EXC  = ADDR_W'(int'(RG_EXC) * 4);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(int'(RG_INT) * 4);

    logic pv;
    always_ff @(posedge clk) pv <= !rst;

    AST_INVAL_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (pv && tlb_inval) |-> $past(bus_wr && bus_addr == A_MMU && bus_size == 2'd2 && wdata_inv)); // R3

    AST_INVAL_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(bus_rd && bus_addr == A_MMU)) |-> !bus_rdata[INV_BIT]); // R3

    AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (pv && asid_flush) |-> $past(bus_wr && bus_addr == A_PTEH && bus_size == 2'd2)); // R4

    AST_CODE_MASK: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(bus_rd && (bus_addr == A_TRAP || bus_addr == A_EXC || bus_addr == A_INT)))
        |-> (bus_rdata[31:CODE_W] == '0)); // R5

    AST_AUX_MASK: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(bus_rd && bus_addr == A_AUX)) |-> (bus_rdata[31:AUX_W] == '0)); // R6

    AST_GATED_ERROR: assert property (@(posedge clk) disable iff (rst)
        (pv && $past((bus_wr || bus_rd) && !feat_en && (bus_addr == A_BUSC || bus_addr == A_BUSD)))
        |-> bus_err); // R7

    AST_ZERO_READS: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(bus_rd && (bus_addr == A_CLK || bus_addr == A_WAIT || bus_addr == A_MEM)))
        |-> (bus_rdata == '0)); // R8

    AST_BYTE_ERROR: assert property (@(posedge clk) disable iff (rst)
        (pv && $past((bus_wr || bus_rd) && bus_size == 2'd0)) |-> bus_err); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pv && !$past(bus_rd)) |-> (bus_rdata == '0)); // R10

    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (pv && bus_err) |-> $past(bus_wr || bus_rd)); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (pv && $past(bus_wr && bus_rd)) |-> (bus_rdata == '0)); // R11
endmodule

bind ctrl_regbank ctrl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .feat_en    (feat_en),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_size   (bus_size),
    .wdata_inv  (bus_wdata[regbank_pkg::INV_BIT]),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .tlb_inval  (tlb_inval),
    .asid_flush (asid_flush)
);

// File: tb/tb_ctrl_regbank.sv
module tb_ctrl_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        feat_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, tlb_inval, asid_flush;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m [0:15];

    always #4 clk = ~clk;

    ctrl_regbank #(.ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .feat_en(feat_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .tlb_inval(tlb_inval), .asid_flush(asid_flush)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input int k);
        case (k)
            1, 2, 4:    return 32'h0000_FFFF;
            5, 6, 7:    return 32'h0;
            8:          return 32'hFFFF_FFFB;
            11:         return 32'h0000_000F;
            12, 13, 14: return 32'h0000_07FF;
            default:    return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string tag_of(input int k, input bit w, input bit r);
        if (w && r) return "R11";
        case (k)
            0, 1, 10, 15: return "R12";
            2, 3:         return "R7";
            4:            return "R2";
            5, 6, 7:      return "R8";
            8:            return "R3";
            9:            return "R4";
            11:           return "R6";
            12, 13, 14:   return "R5";
            default:      return "R9";
        endcase
    endfunction

    task automatic do_acc(input bit w, input bit r, input logic [7:0] a,
                          input logic [1:0] sz, input logic [31:0] d, input string tag_in);
        int k;
        bit mapped, half, szok, legal, gated, eerr, einv, efl;
        logic [31:0] erd;
        string tag;
        k      = int'(a[5:2]);
        mapped = (a[1:0] == 2'b00) && (a[7:6] == 2'b00);
        half   = mapped && (k == 1 || k == 2 || k == 4 || k == 5);
        szok   = half ? (sz == 2'd1) : (sz == 2'd2);
        legal  = mapped && szok && !(w && k == 5);
        gated  = mapped && (k == 2 || k == 3);
        eerr   = (w || r) && (!legal || (gated && !feat_en));
        erd = '0; einv = 1'b0; efl = 1'b0;
        tag = (tag_in.len() != 0) ? tag_in : tag_of(k, w, r);
        if (w && legal) begin
            einv = (k == 8) && d[2];
            efl  = (k == 9) && (d[7:0] != m[9][7:0]);
            m[k] = d & bmask(k);
        end else if (r && legal) begin
            erd = m[k];
            if (k == 4) m[4] = (m[4] + 32'd1) & 32'h0000_FFFF;
        end
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = w; bus_rd = r;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk(tag, "rdata", bus_rdata, erd);
        chk(legal ? tag : "R9", "err", {31'b0, bus_err}, {31'b0, eerr});
        chk(tag, "tlb_inval", {31'b0, tlb_inval}, {31'b0, einv});
        chk(tag, "asid_flush", {31'b0, asid_flush}, {31'b0, efl});
        @(negedge clk);
        chk("R10", "idle rdata", bus_rdata, 32'h0);
        chk("R10", "idle pulses", {29'b0, bus_err, tlb_inval, asid_flush}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs and all-zero contents after reset
        chk("R1", "reset outputs", {bus_rdata[28:0], bus_err, tlb_inval, asid_flush}, 32'h0);
        feat_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            bit h;
            h = (k == 1 || k == 2 || k == 4 || k == 5);
            do_acc(1'b0, 1'b1, 8'(k * 4), h ? 2'd1 : 2'd2, 32'h0, "R1");
        end

        // Sweep: feature setting x offsets (incl. unmapped) x sizes x strobe mix
        for (int f = 0; f < 2; f++) begin
            feat_en = f[0];
            for (int k = 0; k < 18; k++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int op = 0; op < 3; op++) begin
                        logic [31:0] d;
                        d = 32'h9E37_79B9 * 32'(k * 16 + sz * 4 + op + f * 512 + 1);
                        do_acc(op != 1, op != 0, 8'(k * 4), 2'(sz), d, "");
                        if (op == 0) do_acc(1'b0, 1'b1, 8'(k * 4), 2'(sz), 32'h0, "");
                    end
                end
            end
        end

        feat_en = 1'b1;
        // R2: counter wrap
        do_acc(1'b1, 1'b0, 8'h10, 2'd1, 32'h1234_FFFF, "R2");
        do_acc(1'b0, 1'b1, 8'h10, 2'd1, 32'h0, "R2");
        do_acc(1'b0, 1'b1, 8'h10, 2'd1, 32'h0, "R2");
        // R4: same ID byte gives no flush, a different one does
        do_acc(1'b1, 1'b0, 8'h24, 2'd2, 32'h1234_5678, "R4");
        do_acc(1'b1, 1'b0, 8'h24, 2'd2, 32'hABCD_EF78, "R4");
        do_acc(1'b1, 1'b0, 8'h24, 2'd2, 32'hABCD_EF79, "R4");
        do_acc(1'b0, 1'b1, 8'h24, 2'd2, 32'h0, "R4");
        // R3: invalidate bit alone
        do_acc(1'b1, 1'b0, 8'h20, 2'd2, 32'h0000_0004, "R3");
        do_acc(1'b0, 1'b1, 8'h20, 2'd2, 32'h0, "R3");
        // R9: misaligned access is rejected and leaves contents
        do_acc(1'b1, 1'b0, 8'h02, 2'd2, 32'hDEAD_BEEF, "R9");
        do_acc(1'b0, 1'b1, 8'h00, 2'd2, 32'h0, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule